// File: doc/BRIEF.md
# Split-Group Lane Width Negotiator

This block decides how an eight-lane serial port comes up. The port is treated as two four-lane groups, and each group first tries to train by itself. If both groups train and name the same partner, the controller fuses them into one eight-lane link. If they name different partners, it runs them as two separate four-lane links. If only one group trains, it runs just that group. The controller then tries each link at its widest candidate width and moves down through the supported widths (eight, four, one) until the partner accepts.

Training results, partner identities and per-attempt acceptance come in as abstract handshake inputs. The controller drives the width it is currently trying, which link that attempt belongs to, and at the end a one-hot width per link, a count of live links and a one-cycle link-up strobe. A failure at the single-lane width makes it drop the whole port into a link-down hold-off and then restart from the group phase.

Top module: `lane_width_ctrl`

## Requirements
- R1: While reset is held, and after it is released until an outcome is reached, link_up, link_down, link_count, link_width0, link_width1 and attempt_width are all zero. grp_phase is asserted from the first clock edge after reset is released.
- R2: The group phase ends on the clock edge where both grp_ok bits are high, or after timeout_cycles+1 cycles of the phase otherwise.
- R3: If both groups trained and grp_id0 equals grp_id1, a single link is negotiated on link index 0, and its first attempt is at eight lanes.
- R4: If both groups trained with different identities, two links are negotiated one after the other: link 0 first, then link 1, each starting at four lanes. link_count reports 2 at the end.
- R5: If exactly one group trained, only that group's link (index 0 for grp_ok bit 0, index 1 for bit 1) is negotiated, starting at four lanes. The other link's width reads zero.
- R6: If no group trained by the end of the group phase, link_down is raised.
- R7: A failed attempt is retried on the same link at the next narrower width, in the order eight, four, one. The two-lane code is never tried.
- R8: An attempt with neither train_ok nor train_fail lasts timeout_cycles+1 cycles and then counts as a failure. When train_ok and train_fail are high together, train_ok wins.
- R9: A failed single-lane attempt clears all widths and asserts link_down for HOLDOFF_CYC+1 cycles. After that the group phase restarts.
- R10: When the last link is accepted, link_up is high for exactly one cycle. link_count and the widths are valid from that cycle on and are held until reset.
- R11: Width codes are one-hot: bit 0 means one lane, bit 1 means two lanes (reserved, never used), bit 2 means four lanes and bit 3 means eight lanes. attempt_width carries the width under trial and is zero outside attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timeout_cycles | input | TMO_W | Cycle limit for the group phase and for each width attempt |
| grp_ok | input | 2 | Per-group training success, bit 0 is group 0 |
| grp_id0 | input | ID_W | Partner identity seen by group 0 |
| grp_id1 | input | ID_W | Partner identity seen by group 1 |
| train_ok | input | 1 | Current width attempt accepted |
| train_fail | input | 1 | Current width attempt rejected |
| grp_phase | output | 1 | Group phase in progress |
| attempt_width | output | 4 | One-hot width under trial, zero when none |
| attempt_link | output | 1 | Link index of the current attempt |
| link_count | output | 2 | Number of live links once up |
| link_width0 | output | 4 | Final one-hot width of link 0 |
| link_width1 | output | 4 | Final one-hot width of link 1 |
| link_up | output | 1 | One-cycle strobe when negotiation completes |
| link_down | output | 1 | High during the failure hold-off |

## Verification
The bench aims at the points where the group phase chooses between merging, splitting and single-group operation. A design that compared identities wrongly would start at four lanes instead of eight, or would negotiate a second link that does not exist. It drives step-down chains that end both in acceptance and in a single-lane failure. A wrong step order would show a two-lane attempt, and a missing retry would skip the hold-off or fail to restart. It also times attempts that end by silence, and it raises acceptance and rejection together. An off-by-one in the timer, or a rejection given priority, shows up as a wrong attempt length or a narrower final width.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    localparam logic [3:0] LW_NONE = 4'b0000;
    localparam logic [3:0] LW_X1   = 4'b0001;
    localparam logic [3:0] LW_X2   = 4'b0010;
    localparam logic [3:0] LW_X4   = 4'b0100;
    localparam logic [3:0] LW_X8   = 4'b1000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GROUP,
        ST_TRY,
        ST_DONE,
        ST_DOWN
    } lwc_state_e;

    typedef enum logic [2:0] {
        GO_NONE,
        GO_ONLY0,
        GO_ONLY1,
        GO_SPLIT,
        GO_MERGE
    } grp_out_e;

    typedef struct packed {
        lwc_state_e st;
        logic [3:0] cur_w;
        logic       cur_lnk;
        logic       pend1;
        logic [3:0] w0;
        logic [3:0] w1;
        logic       up;
    } lwc_regs_t;

    // next supported width below the given one; none below a single lane
    function automatic logic [3:0] lw_narrower(input logic [3:0] w);
        case (w)
            LW_X8:   return LW_X4;
            LW_X4:   return LW_X1;
            default: return LW_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lwc_timer.sv
module lwc_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/lwc_merge.sv
module lwc_merge
    import lwc_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic [1:0]      grp_ok,
    input  logic [ID_W-1:0] id0,
    input  logic [ID_W-1:0] id1,
    output grp_out_e        outcome
);
    logic same_partner;

    assign same_partner = (id0 == id1);

    always_comb begin
        case (grp_ok)
            2'b11:   outcome = same_partner ? GO_MERGE : GO_SPLIT;
            2'b01:   outcome = GO_ONLY0;
            2'b10:   outcome = GO_ONLY1;
            default: outcome = GO_NONE;
        endcase
    end

endmodule

// File: rtl/lane_width_ctrl.sv
module lane_width_ctrl
    import lwc_pkg::*;
#(
    parameter int ID_W        = 8,
    parameter int TMO_W       = 8,
    parameter int HOLDOFF_CYC = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMO_W-1:0] timeout_cycles,
    input  logic [1:0]       grp_ok,
    input  logic [ID_W-1:0]  grp_id0,
    input  logic [ID_W-1:0]  grp_id1,
    input  logic             train_ok,
    input  logic             train_fail,
    output logic             grp_phase,
    output logic [3:0]       attempt_width,
    output logic             attempt_link,
    output logic [1:0]       link_count,
    output logic [3:0]       link_width0,
    output logic [3:0]       link_width1,
    output logic             link_up,
    output logic             link_down
);
    localparam logic [TMO_W-1:0] HOLD_LIM = TMO_W'(HOLDOFF_CYC);

    lwc_regs_t  r_d, r_q;
    grp_out_e   outcome;
    logic       tmr_clr;
    logic       tmr_exp;
    logic [TMO_W-1:0] tmr_lim;

    lwc_merge #(.ID_W(ID_W)) u_merge (
        .grp_ok  (grp_ok),
        .id0     (grp_id0),
        .id1     (grp_id1),
        .outcome (outcome)
    );

    assign tmr_lim = (r_q.st == ST_DOWN) ? HOLD_LIM : timeout_cycles;

    lwc_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    always_comb begin
        r_d    = r_q;
        r_d.up = 1'b0;
        case (r_q.st)
            ST_IDLE: r_d.st = ST_GROUP;
            ST_GROUP: begin
                if (grp_ok == 2'b11 || tmr_exp) begin
                    r_d.st    = ST_TRY;
                    r_d.pend1 = 1'b0;
                    r_d.cur_w = LW_X4;
                    case (outcome)
                        GO_MERGE: begin
                            r_d.cur_lnk = 1'b0;
                            r_d.cur_w   = LW_X8;
                        end
                        GO_SPLIT: begin
                            r_d.cur_lnk = 1'b0;
                            r_d.pend1   = 1'b1;
                        end
                        GO_ONLY0: r_d.cur_lnk = 1'b0;
                        GO_ONLY1: r_d.cur_lnk = 1'b1;
                        default: begin
                            r_d.st    = ST_DOWN;
                            r_d.cur_w = LW_NONE;
                        end
                    endcase
                end
            end
            ST_TRY: begin
                if (train_ok) begin
                    if (r_q.cur_lnk)
                        r_d.w1 = r_q.cur_w;
                    else
                        r_d.w0 = r_q.cur_w;
                    if (r_q.pend1) begin
                        r_d.cur_lnk = 1'b1;
                        r_d.cur_w   = LW_X4;
                        r_d.pend1   = 1'b0;
                    end else begin
                        r_d.st = ST_DONE;
                        r_d.up = 1'b1;
                    end
                end else if (train_fail || tmr_exp) begin
                    if (r_q.cur_w == LW_X1) begin
                        r_d.st    = ST_DOWN;
                        r_d.cur_w = LW_NONE;
                        r_d.pend1 = 1'b0;
                        r_d.w0    = LW_NONE;
                        r_d.w1    = LW_NONE;
                    end else begin
                        r_d.cur_w = lw_narrower(r_q.cur_w);
                    end
                end
            end
            ST_DOWN: begin
                if (tmr_exp)
                    r_d.st = ST_GROUP;
            end
            default: ;
        endcase
        tmr_clr = (r_d.st != r_q.st) || (r_d.cur_w != r_q.cur_w) ||
                  (r_d.cur_lnk != r_q.cur_lnk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st      <= ST_IDLE;
            r_q.cur_w   <= LW_NONE;
            r_q.cur_lnk <= 1'b0;
            r_q.pend1   <= 1'b0;
            r_q.w0      <= LW_NONE;
            r_q.w1      <= LW_NONE;
            r_q.up      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    logic done_st;
    assign done_st       = (r_q.st == ST_DONE);
    assign grp_phase     = (r_q.st == ST_GROUP);
    assign attempt_width = (r_q.st == ST_TRY) ? r_q.cur_w : LW_NONE;
    assign attempt_link  = r_q.cur_lnk;
    assign link_width0   = done_st ? r_q.w0 : LW_NONE;
    assign link_width1   = done_st ? r_q.w1 : LW_NONE;
    assign link_count    = done_st ? ({1'b0, |r_q.w0} + {1'b0, |r_q.w1}) : 2'd0;
    assign link_up       = r_q.up;
    assign link_down     = (r_q.st == ST_DOWN);

    AST_MERGE_X8: assert property (@(posedge clk) disable iff (rst)
        (grp_phase && grp_ok == 2'b11 && grp_id0 == grp_id1)
        |=> (attempt_width == LW_X8 && !attempt_link)); // R3

    AST_STEP_NARROWER: assert property (@(posedge clk) disable iff (rst)
        (attempt_width != LW_NONE && attempt_width != LW_X1 && train_fail && !train_ok)
        |=> (attempt_width < $past(attempt_width) && attempt_width != LW_X2)); // R7

    AST_X1_FAIL_DOWN: assert property (@(posedge clk) disable iff (rst)
        (attempt_width == LW_X1 && train_fail && !train_ok) |=> link_down); // R9

    AST_UP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        link_up |=> !link_up); // R10

    AST_UP_HAS_LINK: assert property (@(posedge clk) disable iff (rst)
        link_up |-> (link_count != 2'd0 && !link_down)); // R10

    AST_ATTEMPT_CODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(attempt_width) && !attempt_width[1]); // R11

    AST_OK_WINS: assert property (@(posedge clk) disable iff (rst)
        (attempt_width != LW_NONE && train_ok && train_fail && !r_q.pend1)
        |=> link_up); // R8

    AST_NO_GROUP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (grp_phase && grp_ok == 2'b00 && tmr_exp) |=> link_down); // R6

endmodule

// File: tb/lane_width_ctrl_bench.sv
module lane_width_ctrl_bench;
    localparam int HALF  = 10;
    localparam int TMO   = 5;
    localparam int HOLD  = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] timeout_cycles = 8'(TMO);
    logic [1:0] grp_ok = 2'b00;
    logic [7:0] grp_id0 = 8'h00;
    logic [7:0] grp_id1 = 8'h00;
    logic       train_ok = 1'b0;
    logic       train_fail = 1'b0;
    logic       grp_phase;
    logic [3:0] attempt_width;
    logic       attempt_link;
    logic [1:0] link_count;
    logic [3:0] link_width0;
    logic [3:0] link_width1;
    logic       link_up;
    logic       link_down;

    always #HALF clk = ~clk;

    lane_width_ctrl #(.ID_W(8), .TMO_W(8), .HOLDOFF_CYC(HOLD)) u_lane_width_ctrl (
        .clk(clk), .rst(rst), .timeout_cycles(timeout_cycles),
        .grp_ok(grp_ok), .grp_id0(grp_id0), .grp_id1(grp_id1),
        .train_ok(train_ok), .train_fail(train_fail),
        .grp_phase(grp_phase), .attempt_width(attempt_width),
        .attempt_link(attempt_link), .link_count(link_count),
        .link_width0(link_width0), .link_width1(link_width1),
        .link_up(link_up), .link_down(link_down)
    );

    typedef struct {
        logic       lnk;
        logic [3:0] w;
        string      tag;
    } att_t;

    att_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;

    logic [3:0] cap0 = 4'd0;
    logic [3:0] cap1 = 4'd0;
    logic       silent = 1'b0;
    logic       both_mode = 1'b0;

    int up_seen = 0;
    int x8_cyc = 0;
    int grp_cyc = 0;
    int down_cyc = 0;
    logic [3:0] prev_w = 4'd0;
    logic       prev_l = 1'b0;

    task automatic check(input logic cond, input string tag, input int act, input int expv);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic l, input logic [3:0] w, input string tag);
        att_t a;
        a.lnk = l;
        a.w = w;
        a.tag = tag;
        exp_q.push_back(a);
    endtask

    // responder: partner accepts any width up to its cap
    always @(negedge clk) begin
        logic [3:0] cap;
        logic ok;
        if (attempt_width != 4'd0) begin
            cap = attempt_link ? cap1 : cap0;
            ok = (cap != 4'd0) && (attempt_width <= cap);
            train_ok = ok;
            train_fail = ok ? both_mode : !silent;
        end else begin
            train_ok = 1'b0;
            train_fail = 1'b0;
        end
    end

    // monitor: pop expected attempts as new ones appear
    always @(negedge clk) begin
        if (!rst) begin
            if (attempt_width != 4'd0 &&
                (prev_w == 4'd0 || attempt_width != prev_w || attempt_link != prev_l)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected attempt width", int'(attempt_width), 0);
                end else begin
                    att_t e;
                    e = exp_q.pop_front();
                    check(attempt_width == e.w && attempt_link == e.lnk, e.tag,
                          int'({attempt_link, attempt_width}), int'({e.lnk, e.w}));
                end
            end
            if (link_up) up_seen++;
            if (attempt_width == 4'b1000) x8_cyc++;
            if (grp_phase) grp_cyc++;
            if (link_down) down_cyc++;
        end
        prev_w = attempt_width;
        prev_l = attempt_link;
    end

    task automatic start_case(input logic [1:0] okv, input logic [7:0] i0, input logic [7:0] i1,
                              input logic [3:0] c0, input logic [3:0] c1,
                              input logic sil, input logic bm);
        @(negedge clk);
        rst = 1'b1;
        grp_ok = okv; grp_id0 = i0; grp_id1 = i1;
        cap0 = c0; cap1 = c1; silent = sil; both_mode = bm;
        repeat (2) @(negedge clk);
        up_seen = 0; x8_cyc = 0; grp_cyc = 0; down_cyc = 0;
        rst = 1'b0;
    endtask

    task automatic wait_up(input int lim);
        for (int i = 0; i < lim && up_seen == 0; i++) @(negedge clk);
    endtask

    task automatic end_case(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        check(link_up == 0 && link_down == 0 && link_count == 0 && attempt_width == 0 &&
              link_width0 == 0 && link_width1 == 0 && grp_phase == 0,
              "R1 reset outputs", int'(link_count), 0);
        rst = 1'b0;
        @(negedge clk);
        check(grp_phase == 1'b1, "R1 group phase after reset", int'(grp_phase), 1);
        check(link_count == 0 && link_width0 == 0, "R1 no link before outcome", int'(link_count), 0);

        // merge at full width
        push(1'b0, 4'b1000, "R3 merged first attempt x8");
        start_case(2'b11, 8'h5A, 8'h5A, 4'b1000, 4'b0000, 1'b0, 1'b0);
        wait_up(100);
        check(up_seen == 1, "R10 link_up strobe", up_seen, 1);
        check(link_width0 == 4'b1000, "R3 merged width x8", int'(link_width0), 8);
        check(link_count == 2'd1 && link_width1 == 4'd0, "R3 single link count", int'(link_count), 1);
        repeat (10) @(negedge clk);
        check(up_seen == 1, "R10 strobe lasts one cycle", up_seen, 1);
        check(link_width0 == 4'b1000 && link_count == 2'd1, "R10 result held", int'(link_width0), 8);
        end_case("R3 merge queue empty");

        // merge, partner only takes four lanes
        push(1'b0, 4'b1000, "R7 step from x8");
        push(1'b0, 4'b0100, "R7 step to x4");
        start_case(2'b11, 8'h33, 8'h33, 4'b0100, 4'b0000, 1'b0, 1'b0);
        wait_up(100);
        check(link_width0 == 4'b0100, "R7 merged settles x4", int'(link_width0), 4);
        end_case("R7 queue empty");

        // distinct partners: two links
        push(1'b0, 4'b0100, "R4 link0 starts x4");
        push(1'b0, 4'b0001, "R7 link0 x4 to x1");
        push(1'b1, 4'b0100, "R4 link1 starts x4");
        start_case(2'b11, 8'h11, 8'h22, 4'b0001, 4'b0100, 1'b0, 1'b0);
        wait_up(100);
        check(link_count == 2'd2, "R4 two links", int'(link_count), 2);
        check(link_width0 == 4'b0001 && link_width1 == 4'b0100, "R11 per-link codes",
              int'({link_width1, link_width0}), int'({4'b0100, 4'b0001}));
        end_case("R4 queue empty");

        // only group 1 trains
        push(1'b1, 4'b0100, "R5 group1 link at x4");
        start_case(2'b10, 8'h01, 8'h02, 4'b1000, 4'b0100, 1'b0, 1'b0);
        wait_up(100);
        check(grp_cyc == TMO + 1, "R2 group phase timeout length", grp_cyc, TMO + 1);
        check(link_width1 == 4'b0100 && link_width0 == 4'd0 && link_count == 2'd1,
              "R5 only link1", int'({link_width1, link_width0}), int'({4'b0100, 4'b0000}));
        end_case("R5 queue empty");

        // silent partner: timeouts drive the step-down
        push(1'b0, 4'b1000, "R8 timeout x8");
        push(1'b0, 4'b0100, "R8 timeout x4");
        push(1'b0, 4'b0001, "R8 x1 accepted");
        start_case(2'b11, 8'h77, 8'h77, 4'b0001, 4'b0000, 1'b1, 1'b0);
        wait_up(200);
        check(grp_cyc == 1, "R2 group ends when both train", grp_cyc, 1);
        check(x8_cyc == TMO + 1, "R8 attempt length on timeout", x8_cyc, TMO + 1);
        check(link_width0 == 4'b0001, "R8 final x1 after timeouts", int'(link_width0), 1);
        end_case("R8 timeout queue empty");

        // ok and fail together: ok wins
        push(1'b0, 4'b1000, "R8 ok wins attempt");
        start_case(2'b11, 8'h44, 8'h44, 4'b1000, 4'b0000, 1'b0, 1'b1);
        wait_up(100);
        check(link_width0 == 4'b1000 && up_seen == 1, "R8 ok priority", int'(link_width0), 8);
        end_case("R8 priority queue empty");

        // single-lane failure, hold-off, restart
        push(1'b0, 4'b1000, "R7 fail x8");
        push(1'b0, 4'b0100, "R7 fail x4");
        push(1'b0, 4'b0001, "R9 fail x1");
        push(1'b0, 4'b1000, "R9 restart attempt x8");
        start_case(2'b11, 8'h66, 8'h66, 4'b0000, 4'b0000, 1'b0, 1'b0);
        for (int i = 0; i < 100 && !link_down; i++) @(negedge clk);
        check(link_down == 1'b1, "R9 link_down raised", int'(link_down), 1);
        check(link_count == 0 && link_width0 == 0 && link_up == 0, "R9 nothing reported while down",
              int'(link_count), 0);
        cap0 = 4'b1000;
        wait_up(200);
        check(down_cyc == HOLD + 1, "R9 hold-off length", down_cyc, HOLD + 1);
        check(link_width0 == 4'b1000 && up_seen == 1, "R9 restart succeeds", int'(link_width0), 8);
        end_case("R9 queue empty");

        // no group trains
        push(1'b0, 4'b0100, "R5 retry group0 x4");
        start_case(2'b00, 8'h01, 8'h01, 4'b0100, 4'b0000, 1'b0, 1'b0);
        for (int i = 0; i < 100 && !link_down; i++) @(negedge clk);
        check(link_down == 1'b1 && grp_cyc == TMO + 1, "R6 down when no group trains",
              grp_cyc, TMO + 1);
        grp_ok = 2'b01;
        wait_up(200);
        check(link_width0 == 4'b0100 && link_width1 == 0 && link_count == 1,
              "R5 group0 only after retry", int'(link_width0), 4);
        end_case("R6 queue empty");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule